// File: doc/BRIEF.md
# Pager Batch Synchronization Controller

This block finds and holds batch alignment on a paging bit stream built from batches of 17 code-words of 32 bits (one sync word, then 8 frames of 2 code-words). It drives the radio receiver enable so that the receiver is powered only when the current acquisition mode needs it. Bit-level detectors outside the block report, on the same strobe as a received bit, whether preamble was seen, whether a sync word ended on that bit, whether an enabled address matched, whether a message code-word could not be corrected and whether the running call has ended.

Every received bit arrives with a one-cycle strobe. From these strobes the block keeps a position inside the 544-bit batch, derives the code-word and frame index, and steps through seven modes: idle, switch-on, preamble wait, data receive, data fail, fade recovery and carrier-off. In each mode the receiver enable follows a fixed pattern: full-time, selected slots only, a narrow window around the expected sync position, or a short slice of a long scan period. At the sync slot of a batch that a message runs across, the sync test is skipped and a one-cycle interrupt asks the host to collect the buffered data.

All pins are plain control and status levels. No data stream crosses the boundary, so no valid/ready handshake and no back-pressure apply.

Top module: `pgr_sync_ctrl`

## Requirements
- R1: Mode codes on `mode_o` are 0 idle, 1 switch-on, 2 preamble wait, 3 data receive, 4 data fail, 5 fade recovery, 6 carrier-off; after reset the mode is 0, `rx_en_o` and `irq_o` are low and `bit_pos_o` is 0.
- R2: With `en_i` high, idle moves to switch-on (1) on the next clock; switch-on keeps `rx_en_o` high, goes to mode 2 on preamble, and after 1632 strobes (3 batches) with neither preamble nor sync goes to mode 6.
- R3: Preamble wait (2) keeps `rx_en_o` high; each preamble strobe restarts a 544-strobe window, and when a full window passes with neither sync nor preamble the mode becomes 6.
- R4: A sync strobe in mode 1 or 2 enters mode 3; in mode 3 `rx_en_o` is high when the next bit falls in code-word 0, or in a code-word c of 1..16 whose frame (c-1)/2 has its bit set in `frame_mask_i`, or while a call is active; an address-match strobe in mode 3 starts a call and a call-end strobe stops it.
- R5: A message-failure strobe in mode 3 with a call active enters mode 4 (failure strobes without a call are ignored); mode 4 keeps `rx_en_o` high, and at the next expected sync slot a sync returns to mode 3 with the call kept, while a missing sync enters mode 5 and drops the call.
- R6: In fade recovery (5) `rx_en_o` is high only when the next bit position is within 8 of position 31 (23..39); a sync inside that window enters mode 3, a sync outside it is ignored, and 8160 strobes (15 batches) without success enter mode 6.
- R7: Carrier-off (6) runs a 576-strobe scan (18 code-words) starting at entry, with `rx_en_o` high for the first 32 strobes of each scan; sync or preamble strobes while the receiver is off are ignored.
- R8: Preamble seen in mode 5 inside the window, or in mode 6 while receiving, enters mode 2.
- R9: In mode 3 with a call active, the strobe of the expected sync slot performs no sync test and `irq_o` is high for exactly one cycle after it, with `bit_pos_o` equal to 31.
- R10: Any accepted sync sets `bit_pos_o` to 31 (last bit of code-word 0), so the next expected sync slot is the 544th strobe later; otherwise `bit_pos_o` advances by one per strobe modulo 544, `cw_idx_o` is `bit_pos_o`/32 and `frame_o` is (`cw_idx_o`-1)/2, or 0 for code-word 0.
- R11: In mode 3 with no call active, a missing sync at the expected slot (the strobe whose bit lands at position 31) enters mode 4.
- R12: `en_i` low forces mode 0 on the next clock with `rx_en_o` low and `bit_pos_o` frozen; raising `en_i` again enters mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Decoder on; low forces idle |
| bit_stb_i | input | 1 | One-cycle strobe per received bit |
| preamble_i | input | 1 | Preamble detected at this bit |
| sync_i | input | 1 | Sync word ended at this bit |
| addr_hit_i | input | 1 | Enabled address matched at this bit |
| msg_bad_i | input | 1 | Message code-word uncorrectable |
| call_end_i | input | 1 | Running call terminated |
| frame_mask_i | input | 8 | Enabled address frames, bit f for frame f |
| rx_en_o | output | 1 | Receiver enable |
| mode_o | output | 3 | Current mode code |
| bit_pos_o | output | 10 | Position of last received bit in the batch |
| cw_idx_o | output | 5 | Code-word index of that bit |
| frame_o | output | 3 | Frame index of that bit |
| irq_o | output | 1 | Transfer request at a skipped sync slot |

## Verification
The assertions watch on every cycle that idle keeps the receiver and interrupt quiet, that dropping the enable reaches idle at once, that the acquisition modes hold the receiver on, that a sync in switch-on or preamble wait locks to position 31, that the position stays in range and moves only on strobes, and that the interrupt is a lone pulse at the sync slot of a data-receive batch. The long timeouts (3, 1 and 15 batches), the 1-in-18 carrier scan, the frame-mask gating, the fade window edges and the data-fail return path only show up through the bench's scenarios, which count strobes to the exact boundary and compare against values worked out from the requirements.

// File: rtl/pgr_sync_pkg.sv
package pgr_sync_pkg;

  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_SWON   = 3'd1,
    M_PREAMB = 3'd2,
    M_DATA   = 3'd3,
    M_DFAIL  = 3'd4,
    M_FADE   = 3'd5,
    M_CARR   = 3'd6
  } pgr_mode_e;

  // Code-words carried by one address frame.
  localparam int CW_PER_FRAME = 2;

endpackage

// File: rtl/pgr_step_counter.sv
module pgr_step_counter #(
  parameter int W   = 10,
  parameter int MOD = 576
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (clr) begin
      cnt_o <= '0;
    end else if (inc) begin
      cnt_o <= (cnt_o == LAST) ? '0 : cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/pgr_batch_timer.sv
module pgr_batch_timer #(
  parameter int CW_BITS      = 32,
  parameter int CW_PER_BATCH = 17,
  parameter int WIN          = 8,
  parameter int POS_W        = 10,
  parameter int CW_W         = 5,
  parameter int FR_W         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             realign,
  output logic [POS_W-1:0] pos_o,
  output logic [CW_W-1:0]  cw_o,
  output logic [FR_W-1:0]  frame_o,
  output logic [CW_W-1:0]  nxt_cw_o,
  output logic             at_sync_o,
  output logic             in_win_o
);

  import pgr_sync_pkg::*;

  localparam int BATCH_BITS = CW_BITS * CW_PER_BATCH;
  localparam int LOG_CW     = $clog2(CW_BITS);
  localparam int SYNC_LAST  = CW_BITS - 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BATCH_BITS - 1);
  localparam logic [POS_W-1:0] SYNC_POS = POS_W'(SYNC_LAST);
  localparam logic [POS_W-1:0] WIN_LO   = POS_W'(SYNC_LAST - WIN);
  localparam logic [POS_W-1:0] WIN_HI   = POS_W'(SYNC_LAST + WIN);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] nxt;

  // Position the next received bit will occupy.
  assign nxt = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (realign) begin
      pos_q <= SYNC_POS;
    end else if (adv) begin
      pos_q <= nxt;
    end
  end

  assign pos_o     = pos_q;
  assign cw_o      = CW_W'(pos_q >> LOG_CW);
  assign frame_o   = (cw_o == '0) ? '0 : FR_W'((cw_o - 1'b1) / CW_PER_FRAME);
  assign nxt_cw_o  = CW_W'(nxt >> LOG_CW);
  assign at_sync_o = (nxt == SYNC_POS);
  assign in_win_o  = (nxt >= WIN_LO) && (nxt <= WIN_HI);

endmodule

// File: rtl/pgr_rx_gate.sv
module pgr_rx_gate #(
  parameter int FRAMES       = 8,
  parameter int CW_PER_BATCH = 17,
  parameter int CW_W         = 5
) (
  input  pgr_sync_pkg::pgr_mode_e mode,
  input  logic [CW_W-1:0]         nxt_cw,
  input  logic [FRAMES-1:0]       frame_mask,
  input  logic                    call_act,
  input  logic                    scan_on,
  input  logic                    in_win,
  output logic                    rx_en
);

  import pgr_sync_pkg::*;

  logic [CW_PER_BATCH-1:0] cw_en;
  logic                    slot_on;

  // Code-word 0 is the sync slot; the rest map pairwise onto frames.
  for (genvar c = 0; c < CW_PER_BATCH; c++) begin : g_slot
    if (c == 0) begin : g_sync
      assign cw_en[c] = 1'b1;
    end else begin : g_frame
      assign cw_en[c] = frame_mask[(c - 1) / CW_PER_FRAME];
    end
  end

  assign slot_on = (nxt_cw < CW_W'(CW_PER_BATCH)) && cw_en[nxt_cw];

  always_comb begin
    case (mode)
      M_SWON, M_PREAMB, M_DFAIL: rx_en = 1'b1;
      M_DATA:                    rx_en = call_act || slot_on;
      M_FADE:                    rx_en = in_win;
      M_CARR:                    rx_en = scan_on;
      default:                   rx_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/pgr_sync_ctrl.sv
module pgr_sync_ctrl #(
  parameter int CW_BITS      = 32,
  parameter int FRAMES       = 8,
  parameter int SWON_BATCHES = 3,
  parameter int PRE_BATCHES  = 1,
  parameter int FADE_BATCHES = 15,
  parameter int FADE_WIN     = 8,
  parameter int SCAN_PERIOD  = 18,
  parameter int SCAN_ON      = 1,
  localparam int CW_PER_BATCH = FRAMES * pgr_sync_pkg::CW_PER_FRAME + 1,
  localparam int BATCH_BITS   = CW_BITS * CW_PER_BATCH,
  localparam int POS_W        = $clog2(BATCH_BITS),
  localparam int CW_W         = $clog2(CW_PER_BATCH),
  localparam int FR_W         = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              bit_stb_i,
  input  logic              preamble_i,
  input  logic              sync_i,
  input  logic              addr_hit_i,
  input  logic              msg_bad_i,
  input  logic              call_end_i,
  input  logic [FRAMES-1:0] frame_mask_i,
  output logic              rx_en_o,
  output logic [2:0]        mode_o,
  output logic [POS_W-1:0]  bit_pos_o,
  output logic [CW_W-1:0]   cw_idx_o,
  output logic [FR_W-1:0]   frame_o,
  output logic              irq_o
);

  import pgr_sync_pkg::*;

  localparam int SWON_LEN = SWON_BATCHES * BATCH_BITS;
  localparam int PRE_LEN  = PRE_BATCHES * BATCH_BITS;
  localparam int FADE_LEN = FADE_BATCHES * BATCH_BITS;
  localparam int DW_MAX   = (SWON_LEN > FADE_LEN) ?
                            ((SWON_LEN > PRE_LEN) ? SWON_LEN : PRE_LEN) :
                            ((FADE_LEN > PRE_LEN) ? FADE_LEN : PRE_LEN);
  localparam int DW_W     = $clog2(DW_MAX + 1);
  localparam int SCAN_LEN = SCAN_PERIOD * CW_BITS;
  localparam int SCAN_ONB = SCAN_ON * CW_BITS;
  localparam int SC_W     = $clog2(SCAN_LEN);

  pgr_mode_e        mode_q, mode_n;
  logic             call_q, call_set, call_clr;
  logic             irq_q, irq_n;
  logic             realign, pre_restart;
  logic             dwell_clr, dwell_inc, expire;
  logic [DW_W-1:0]  dwell_cnt, dwell_lim;
  logic [SC_W-1:0]  scan_cnt;
  logic             scan_on;
  logic             adv;
  logic [CW_W-1:0]  nxt_cw;
  logic             at_sync, in_win;
  logic             stb;

  assign stb = bit_stb_i && en_i;
  assign adv = stb && (mode_q != M_IDLE);

  // Batch position, code-word and frame tracking.
  pgr_batch_timer #(
    .CW_BITS     (CW_BITS),
    .CW_PER_BATCH(CW_PER_BATCH),
    .WIN         (FADE_WIN),
    .POS_W       (POS_W),
    .CW_W        (CW_W),
    .FR_W        (FR_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .realign  (realign),
    .pos_o    (bit_pos_o),
    .cw_o     (cw_idx_o),
    .frame_o  (frame_o),
    .nxt_cw_o (nxt_cw),
    .at_sync_o(at_sync),
    .in_win_o (in_win)
  );

  // Strobes spent in the current mode, for the batch-length timeouts.
  assign dwell_clr = (mode_n != mode_q) || pre_restart || (mode_q == M_IDLE);
  assign dwell_inc = stb;

  pgr_step_counter #(
    .W  (DW_W),
    .MOD(2 ** DW_W)
  ) u_dwell (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (dwell_clr),
    .inc  (dwell_inc),
    .cnt_o(dwell_cnt)
  );

  always_comb begin
    case (mode_q)
      M_SWON:   dwell_lim = DW_W'(SWON_LEN - 1);
      M_PREAMB: dwell_lim = DW_W'(PRE_LEN - 1);
      M_FADE:   dwell_lim = DW_W'(FADE_LEN - 1);
      default:  dwell_lim = '1;
    endcase
  end

  assign expire = stb && (dwell_cnt == dwell_lim);

  // Carrier-off scan: held at zero outside the mode, so entry starts a slice.
  pgr_step_counter #(
    .W  (SC_W),
    .MOD(SCAN_LEN)
  ) u_scan (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (mode_q != M_CARR),
    .inc  (stb && (mode_q == M_CARR)),
    .cnt_o(scan_cnt)
  );

  assign scan_on = (scan_cnt < SC_W'(SCAN_ONB));

  // Mode transitions.
  always_comb begin
    mode_n      = mode_q;
    realign     = 1'b0;
    pre_restart = 1'b0;
    irq_n       = 1'b0;
    call_set    = 1'b0;
    call_clr    = 1'b0;
    if (!en_i) begin
      mode_n   = M_IDLE;
      call_clr = 1'b1;
    end else begin
      case (mode_q)
        M_IDLE: mode_n = M_SWON;
        M_SWON: begin
          if (stb) begin
            if (sync_i) begin
              mode_n  = M_DATA;
              realign = 1'b1;
            end else if (preamble_i) begin
              mode_n = M_PREAMB;
            end else if (expire) begin
              mode_n = M_CARR;
            end
          end
        end
        M_PREAMB: begin
          if (stb) begin
            if (sync_i) begin
              mode_n  = M_DATA;
              realign = 1'b1;
            end else if (preamble_i) begin
              pre_restart = 1'b1;
            end else if (expire) begin
              mode_n = M_CARR;
            end
          end
        end
        M_DATA: begin
          if (stb) begin
            if (at_sync) begin
              if (call_q) begin
                irq_n = 1'b1;
              end else if (sync_i) begin
                realign = 1'b1;
              end else begin
                mode_n = M_DFAIL;
              end
            end else begin
              if (call_q && msg_bad_i) begin
                mode_n = M_DFAIL;
              end
              if (addr_hit_i) begin
                call_set = 1'b1;
              end else if (call_end_i) begin
                call_clr = 1'b1;
              end
            end
          end
        end
        M_DFAIL: begin
          if (stb) begin
            if (at_sync) begin
              if (sync_i) begin
                mode_n  = M_DATA;
                realign = 1'b1;
              end else begin
                mode_n   = M_FADE;
                call_clr = 1'b1;
              end
            end else if (call_end_i) begin
              call_clr = 1'b1;
            end
          end
        end
        M_FADE: begin
          if (stb) begin
            if (in_win && sync_i) begin
              mode_n  = M_DATA;
              realign = 1'b1;
            end else if (in_win && preamble_i) begin
              mode_n = M_PREAMB;
            end else if (expire) begin
              mode_n = M_CARR;
            end
          end
        end
        M_CARR: begin
          if (stb && scan_on) begin
            if (sync_i) begin
              mode_n  = M_DATA;
              realign = 1'b1;
            end else if (preamble_i) begin
              mode_n = M_PREAMB;
            end
          end
        end
        default: mode_n = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;
      call_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      irq_q  <= irq_n;
      if (call_clr) begin
        call_q <= 1'b0;
      end else if (call_set) begin
        call_q <= 1'b1;
      end
    end
  end

  pgr_rx_gate #(
    .FRAMES      (FRAMES),
    .CW_PER_BATCH(CW_PER_BATCH),
    .CW_W        (CW_W)
  ) u_gate (
    .mode      (mode_q),
    .nxt_cw    (nxt_cw),
    .frame_mask(frame_mask_i),
    .call_act  (call_q),
    .scan_on   (scan_on),
    .in_win    (in_win),
    .rx_en     (rx_en_o)
  );

  assign mode_o = mode_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/pgr_sync_ctrl_chk.sv
module pgr_sync_ctrl_chk #(
  parameter int POS_W      = 10,
  parameter int BATCH_BITS = 544,
  parameter int SYNC_LAST  = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             bit_stb_i,
  input logic             sync_i,
  input logic [2:0]       mode_o,
  input logic             rx_en_o,
  input logic             irq_o,
  input logic [POS_W-1:0] bit_pos_o
);

  import pgr_sync_pkg::*;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_IDLE) |-> (!rx_en_o && !irq_o));  // R12

  AST_OFF_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (mode_o == M_IDLE));  // R12

  AST_ACQ_RX_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_SWON || mode_o == M_PREAMB || mode_o == M_DFAIL) |-> rx_en_o);  // R2

  AST_SYNC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && bit_stb_i && sync_i && (mode_o == M_SWON || mode_o == M_PREAMB))
    |=> (mode_o == M_DATA && bit_pos_o == POS_W'(SYNC_LAST)));  // R10

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos_o < POS_W'(BATCH_BITS));  // R10

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb_i |=> $stable(bit_pos_o));  // R10

  AST_IRQ_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mode_o == M_DATA && bit_pos_o == POS_W'(SYNC_LAST)));  // R9

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);  // R9

endmodule

bind pgr_sync_ctrl pgr_sync_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_i     (en_i),
  .bit_stb_i(bit_stb_i),
  .sync_i   (sync_i),
  .mode_o   (mode_o),
  .rx_en_o  (rx_en_o),
  .irq_o    (irq_o),
  .bit_pos_o(bit_pos_o)
);

// File: tb/pgr_sync_ctrl_tb.sv
module pgr_sync_ctrl_tb;

  localparam int BB = 544;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       stb = 1'b0;
  logic       pre = 1'b0, syn = 1'b0, ahit = 1'b0, mbad = 1'b0, cend = 1'b0;
  logic [7:0] fmask = 8'h00;
  logic       rx, irq;
  logic [2:0] mode;
  logic [9:0] bpos;
  logic [4:0] cwi;
  logic [2:0] frm;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int bp      = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pgr_sync_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .bit_stb_i   (stb),
    .preamble_i  (pre),
    .sync_i      (syn),
    .addr_hit_i  (ahit),
    .msg_bad_i   (mbad),
    .call_end_i  (cend),
    .frame_mask_i(fmask),
    .rx_en_o     (rx),
    .mode_o      (mode),
    .bit_pos_o   (bpos),
    .cw_idx_o    (cwi),
    .frame_o     (frm),
    .irq_o       (irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One bit strobe with the given detector flags; starts and ends at a falling edge.
  task automatic pulse(input bit p, input bit s, input bit a, input bit m, input bit c);
    pre = p; syn = s; ahit = a; mbad = m; cend = c; stb = 1'b1;
    @(negedge clk);
    pre = 0; syn = 0; ahit = 0; mbad = 0; cend = 0; stb = 1'b0;
    bp = (bp + 1) % BB;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) pulse(0, 0, 0, 0, 0);
  endtask

  task automatic walk_to(input int target);
    idle((target - bp + BB) % BB);
  endtask

  function automatic int exp_rx_data(input int pos, input logic [7:0] m, input bit call);
    int nx = (pos + 1) % BB;
    int c  = nx / 32;
    if (call || c == 0) return 1;
    return int'(m[(c - 1) / 2]);
  endfunction

  function automatic int exp_frame(input int pos);
    int c = pos / 32;
    return (c == 0) ? 0 : (c - 1) / 2;
  endfunction

  // Drive the machine from data receive into fade recovery (no call active).
  task automatic go_fade();
    walk_to(30); pulse(0, 0, 0, 0, 0);   // missing sync -> data fail
    walk_to(30); pulse(0, 0, 0, 0, 0);   // missing again -> fade
  endtask

  initial begin
    int r, errs, held;
    void'($urandom(32'd5150));
    fmask = 8'($urandom) & 8'h7F;
    if (fmask == 8'h00) fmask = 8'h05;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset rx", int'(rx), 0);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset pos", int'(bpos), 0);

    en = 1'b1;
    @(negedge clk);
    chk("R2 switch-on entry", int'(mode), 1);
    chk("R2 switch-on rx", int'(rx), 1);
    idle(1631);
    chk("R2 before timeout", int'(mode), 1);
    idle(1);
    chk("R2 timeout to carrier-off", int'(mode), 6);
    chk("R7 scan slice on at entry", int'(rx), 1);

    idle(32);
    chk("R7 scan slice off", int'(rx), 0);
    pulse(0, 1, 0, 0, 0);
    chk("R7 sync ignored while off", int'(mode), 6);
    pulse(1, 0, 0, 0, 0);
    chk("R7 preamble ignored while off", int'(mode), 6);
    idle(542);
    chk("R7 next scan slice on", int'(rx), 1);
    r = 1 + int'($urandom % 31);
    idle(r);
    chk("R7 still inside slice", int'(rx), 1);
    pulse(1, 0, 0, 0, 0);
    chk("R8 carrier-off preamble", int'(mode), 2);

    chk("R3 preamble wait rx", int'(rx), 1);
    idle(100 + int'($urandom % 300));
    pulse(1, 0, 0, 0, 0);
    idle(543);
    chk("R3 window restarted", int'(mode), 2);
    idle(1);
    chk("R3 window expiry", int'(mode), 6);

    pulse(1, 0, 0, 0, 0);
    chk("R8 preamble at scan start", int'(mode), 2);
    pulse(0, 1, 0, 0, 0);
    bp = 31;
    chk("R4 sync enters data receive", int'(mode), 3);
    chk("R10 realign position", int'(bpos), 31);
    chk("R10 code-word of sync", int'(cwi), 0);

    errs = 0;
    for (int i = 0; i < 543; i++) begin
      if (int'(rx) != exp_rx_data(bp, fmask, 0)) errs++;
      if (int'(bpos) != bp) errs++;
      pulse(0, 0, 0, 0, 0);
    end
    chk("R4 frame gating mismatches", errs, 0);
    pulse(0, 1, 0, 0, 0);
    chk("R10 sync 544 strobes later", int'(bpos), 31);
    chk("R11 sync held, mode", int'(mode), 3);

    r = 40 + int'($urandom % 400);
    walk_to(r);
    chk("R10 code-word index", int'(cwi), r / 32);
    chk("R10 frame index", int'(frm), exp_frame(r));
    pulse(0, 0, 1, 0, 0);
    walk_to(479);
    chk("R4 call keeps rx in masked frame", int'(rx), 1);
    walk_to(30);
    pulse(0, 0, 0, 0, 0);
    chk("R9 irq at skipped sync", int'(irq), 1);
    chk("R9 no sync test with call", int'(mode), 3);
    chk("R9 irq position", int'(bpos), 31);
    @(negedge clk);
    chk("R9 irq single cycle", int'(irq), 0);

    pulse(0, 0, 0, 1, 0);
    chk("R5 failure enters data fail", int'(mode), 4);
    chk("R5 data fail rx", int'(rx), 1);
    walk_to(30);
    pulse(0, 1, 0, 0, 0);
    chk("R5 sync returns to data receive", int'(mode), 3);
    walk_to(479);
    chk("R5 call kept after return", int'(rx), 1);
    pulse(0, 0, 0, 0, 1);
    pulse(0, 0, 0, 1, 0);
    chk("R5 failure without call ignored", int'(mode), 3);
    walk_to(30);
    pulse(0, 0, 0, 0, 0);
    chk("R11 missing sync enters data fail", int'(mode), 4);
    walk_to(30);
    pulse(0, 0, 0, 0, 0);
    chk("R5 missing sync enters fade", int'(mode), 5);
    walk_to(479);
    chk("R5 call dropped in fade", int'(rx), 0);

    walk_to(9);
    pulse(0, 1, 0, 0, 0);
    chk("R6 sync outside window ignored", int'(mode), 5);
    walk_to(21);
    chk("R6 rx off below window", int'(rx), 0);
    pulse(0, 0, 0, 0, 0);
    chk("R6 rx on at window edge", int'(rx), 1);
    walk_to(35);
    pulse(0, 1, 0, 0, 0);
    bp = 31;
    chk("R6 sync in window", int'(mode), 3);
    chk("R10 realign from window", int'(bpos), 31);

    go_fade();
    walk_to(27);
    pulse(1, 0, 0, 0, 0);
    chk("R8 fade preamble", int'(mode), 2);
    pulse(0, 1, 0, 0, 0);
    bp = 31;
    go_fade();
    chk("R6 fade entered again", int'(mode), 5);
    idle(8159);
    chk("R6 before fade timeout", int'(mode), 5);
    idle(1);
    chk("R6 fade timeout", int'(mode), 6);

    pulse(0, 1, 0, 0, 0);
    bp = 31;
    chk("R7 sync in slice", int'(mode), 3);
    idle(5);
    held = int'(bpos);
    en = 1'b0;
    @(negedge clk);
    chk("R12 off forces idle", int'(mode), 0);
    chk("R12 off rx low", int'(rx), 0);
    for (int i = 0; i < 5; i++) begin
      stb = 1'b1; @(negedge clk); stb = 1'b0;
    end
    chk("R12 position frozen", int'(bpos), held);
    en = 1'b1;
    @(negedge clk);
    chk("R12 back to switch-on", int'(mode), 1);
    pulse(0, 1, 0, 0, 0);
    chk("R4 switch-on sync", int'(mode), 3);
    chk("R10 switch-on realign", int'(bpos), 31);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule